// File: doc/BRIEF.md
# PWM Channel Fault Guard

This block protects the channels of a multi-channel PWM generator against external fault conditions. Each fault input has a programmable active level and a behaviour mode. A per-channel mask selects which faults can act on each channel. While a channel is enabled and one of its selected faults is in effect, the channel's high-side and low-side drives are replaced by programmed safe levels and its period counter is held at zero.

The override path is purely combinational from the fault pins, so an unfiltered fault can force the drives even while the PWM clock is stopped. Each fault has a status flag. In follow mode the flag tracks the pin. In latch mode the flag holds until it is cleared while the pin is inactive, and a latched flag keeps protecting its channels. A fault interrupt is raised when any channel enters protection, provided the interrupt is enabled. A status read clears the interrupt even if the fault is still present.

When protection is removed, the drives stay at their safe levels for one more cycle. Normal generation then resumes at a fresh period start, with the counter at zero. A compare unit on channel 0 never reports a match while that channel is forced.

Top module: `pwm_fault_guard`

## Requirements
- R1: Fault f is active when `fault_in[f]` equals `flt_pol[f]`: polarity 1 means a high level is active, polarity 0 means a low level is active.
- R2: Channel c is protected when `ch_en[c]` is 1 and some fault f with mask bit `flt_mask[c*NF+f]` set is in effect. A forced channel drives `pwm_hi[c]=safe_hi[c]` and `pwm_lo[c]=safe_lo[c]`.
- R3: Protection and the forced drive levels follow the fault pins combinationally, with no clock edge required.
- R4: A channel counter is 0 after reset, is held at 0 while the channel is disabled or forced, and otherwise counts 0, 1, …, period-1 and then wraps to 0. A period of 0 or 1 keeps it at 0.
- R5: An enabled, unforced channel drives `pwm_hi = (count < duty)` and `pwm_lo` as its complement. A disabled channel drives both outputs to 0.
- R6: In follow mode (`flt_mode[f]=0`), `flt_stat[f]` equals the active state of fault f in the previous cycle. It is 0 after reset.
- R7: In latch mode (`flt_mode[f]=1`), `flt_stat[f]` is set by activity and stays 1 until `flt_clr[f]` is 1 in a cycle where the fault is inactive. While the flag is set, the fault stays in effect for R2.
- R8: After a channel leaves protection, its forced levels remain for exactly one more cycle. The next cycle starts a new period with count 0.
- R9: `irq` becomes 1 one cycle after any cycle in which `irq_en` is 1 and at least one channel goes from unprotected to protected. It stays 1 until cleared.
- R10: `status_rd` clears `irq` in the next cycle, even while a fault persists. If a new protection entry with `irq_en` falls in the same cycle as the read, the set wins.
- R11: `cmp_match` is 1 exactly when channel 0 is enabled, not forced, and its count equals `cmp_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_in | input | NF | Raw fault pins |
| flt_pol | input | NF | Active level per fault |
| flt_mode | input | NF | 0 follow, 1 latch |
| flt_clr | input | NF | Clear request for latched flags |
| flt_mask | input | NCH*NF | Fault-select mask, bit c*NF+f |
| ch_en | input | NCH | Channel enable |
| safe_hi | input | NCH | Forced high-side level |
| safe_lo | input | NCH | Forced low-side level |
| duty | input | NCH*CW | Duty value, channel c at c*CW |
| period | input | CW | Period length shared by channels |
| cmp_val | input | CW | Compare value for channel 0 |
| irq_en | input | 1 | Fault interrupt enable |
| status_rd | input | 1 | Status read strobe, clears irq |
| pwm_hi | output | NCH | High-side drives |
| pwm_lo | output | NCH | Low-side drives |
| ch_cnt | output | NCH*CW | Channel counters |
| flt_stat | output | NF | Fault status flags |
| irq | output | 1 | Fault interrupt |
| cmp_match | output | 1 | Channel 0 compare match |

## Verification
Two events can fall in the same cycle: an interrupt-clearing status read and a fresh protection entry that sets the interrupt. The bench forces this overlap in a directed case, with the interrupt already pending when a new fault edge arrives together with the read, and expects the interrupt to remain high. Random stimulus also produces the overlap, and a cycle model built from the requirements judges it. A second overlap is a latched flag meeting a clear request while its pin is still active; the expected result is that the clear is refused.

// File: rtl/pwm_fault_guard_pkg.sv
package pwm_fault_guard_pkg;

    typedef enum logic {
        FMODE_FOLLOW = 1'b0,
        FMODE_LATCH  = 1'b1
    } fault_mode_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } drive_t;

    // A pin is active when its level equals the programmed polarity
    function automatic logic pin_active(input logic level, input logic pol);
        return ~(level ^ pol);
    endfunction

    // Next value of a fault status flag
    function automatic logic flag_next(input logic act, input fault_mode_e m,
                                       input logic flag, input logic clr);
        return act | ((m == FMODE_LATCH) & flag & ~clr);
    endfunction

endpackage

// File: rtl/pfg_fault_detect.sv
module pfg_fault_detect
    import pwm_fault_guard_pkg::*;
#(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] fault_in,
    input  logic [NF-1:0] pol,
    input  logic [NF-1:0] mode,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] eff,
    output logic [NF-1:0] stat
);
    logic [NF-1:0] active;
    logic [NF-1:0] stat_q;

    for (genvar f = 0; f < NF; f++) begin : g_fault
        fault_mode_e fm;
        assign fm        = fault_mode_e'(mode[f]);
        assign active[f] = pin_active(fault_in[f], pol[f]);
        assign eff[f]    = active[f] | ((fm == FMODE_LATCH) & stat_q[f]);

        always_ff @(posedge clk) begin
            if (rst) stat_q[f] <= 1'b0;
            else     stat_q[f] <= flag_next(active[f], fm, stat_q[f], clr[f]);
        end

        // R7: a latched flag survives every cycle without a clear
        assert_latch_holds_R7: assert property (@(posedge clk) disable iff (rst)
            (mode[f] && stat_q[f] && !clr[f]) |=> stat_q[f])
            else $error("latched flag dropped");

        // R6: follow mode drops the flag after an inactive cycle
        assert_follow_drop_R6: assert property (@(posedge clk) disable iff (rst)
            (!mode[f] && (fault_in[f] != pol[f])) |=> !stat_q[f])
            else $error("follow flag stuck");
    end

    assign stat = stat_q;
endmodule

// File: rtl/pfg_channel.sv
module pfg_channel
    import pwm_fault_guard_pkg::*;
#(
    parameter int NF = 4,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [NF-1:0] mask,
    input  logic [NF-1:0] eff,
    input  drive_t        safe,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] period,
    output drive_t        drv,
    output logic [CW-1:0] cnt,
    output logic          forced,
    output logic          prot
);
    logic          hold_q;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_inc;
    logic [CW-1:0] cnt_d;
    logic          duty_on;

    assign prot    = en & |(mask & eff);
    assign forced  = prot | hold_q;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign duty_on = cnt_q < duty;

    always_comb begin
        if (!en || forced)                  cnt_d = '0;
        else if (cnt_inc >= {1'b0, period}) cnt_d = '0;
        else                                cnt_d = cnt_inc[CW-1:0];
    end

    always_comb begin
        if (forced)  drv = safe;
        else if (en) drv = '{hs: duty_on, ls: ~duty_on};
        else         drv = '{hs: 1'b0, ls: 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            hold_q <= prot;
            cnt_q  <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R4: a protected channel shows a zero count next cycle
    assert_counter_held_R4: assert property (@(posedge clk) disable iff (rst)
        prot |=> (cnt == '0))
        else $error("counter ran under protection");

    // R8: forcing outlasts protection by a cycle
    assert_release_hold_R8: assert property (@(posedge clk) disable iff (rst)
        prot |=> forced)
        else $error("forcing released early");
endmodule

// File: rtl/pfg_irq.sv
module pfg_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] prot,
    input  logic           irq_en,
    input  logic           status_rd,
    output logic           irq
);
    logic [NCH-1:0] prot_q;
    logic           irq_q;
    logic           entry;

    assign entry = |(prot & ~prot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prot_q <= prot;
            if (irq_en && entry) irq_q <= 1'b1;
            else if (status_rd)  irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    // R9: an enabled protection entry raises the interrupt
    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_en && entry) |=> irq)
        else $error("interrupt not raised");

    // R10: a read with interrupts disabled always clears
    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !irq_en) |=> !irq)
        else $error("interrupt not cleared by read");
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pwm_fault_guard_pkg::*;
#(
    parameter int NF  = 4,
    parameter int NCH = 4,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NF-1:0]     fault_in,
    input  logic [NF-1:0]     flt_pol,
    input  logic [NF-1:0]     flt_mode,
    input  logic [NF-1:0]     flt_clr,
    input  logic [NCH*NF-1:0] flt_mask,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    safe_hi,
    input  logic [NCH-1:0]    safe_lo,
    input  logic [NCH*CW-1:0] duty,
    input  logic [CW-1:0]     period,
    input  logic [CW-1:0]     cmp_val,
    input  logic              irq_en,
    input  logic              status_rd,
    output logic [NCH-1:0]    pwm_hi,
    output logic [NCH-1:0]    pwm_lo,
    output logic [NCH*CW-1:0] ch_cnt,
    output logic [NF-1:0]     flt_stat,
    output logic              irq,
    output logic              cmp_match
);
    logic [NF-1:0]  eff;
    logic [NCH-1:0] forced;
    logic [NCH-1:0] prot;

    pfg_fault_detect #(.NF(NF)) i_detect (
        .clk      (clk),
        .rst      (rst),
        .fault_in (fault_in),
        .pol      (flt_pol),
        .mode     (flt_mode),
        .clr      (flt_clr),
        .eff      (eff),
        .stat     (flt_stat)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        drive_t safe_c;
        drive_t drv_c;
        assign safe_c    = '{hs: safe_hi[c], ls: safe_lo[c]};
        assign pwm_hi[c] = drv_c.hs;
        assign pwm_lo[c] = drv_c.ls;

        pfg_channel #(.NF(NF), .CW(CW)) i_chan (
            .clk    (clk),
            .rst    (rst),
            .en     (ch_en[c]),
            .mask   (flt_mask[c*NF +: NF]),
            .eff    (eff),
            .safe   (safe_c),
            .duty   (duty[c*CW +: CW]),
            .period (period),
            .drv    (drv_c),
            .cnt    (ch_cnt[c*CW +: CW]),
            .forced (forced[c]),
            .prot   (prot[c])
        );
    end

    pfg_irq #(.NCH(NCH)) i_irq (
        .clk       (clk),
        .rst       (rst),
        .prot      (prot),
        .irq_en    (irq_en),
        .status_rd (status_rd),
        .irq       (irq)
    );

    assign cmp_match = ch_en[0] & ~forced[0] & (ch_cnt[CW-1:0] == cmp_val);

    // R11: channel 0 in protection never reports a compare match
    assert_no_match_in_fault_R11: assert property (@(posedge clk) disable iff (rst)
        prot[0] |-> !cmp_match)
        else $error("compare matched during fault");
endmodule

// File: tb/test_pwm_fault_guard.sv
module test_pwm_fault_guard;
    localparam int NF = 4;
    localparam int NCH = 4;
    localparam int CW = 8;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              clk_run = 1'b1;
    logic              rst;
    logic [NF-1:0]     fault_in, flt_pol, flt_mode, flt_clr;
    logic [NCH*NF-1:0] flt_mask;
    logic [NCH-1:0]    ch_en, safe_hi, safe_lo;
    logic [NCH*CW-1:0] duty;
    logic [CW-1:0]     period, cmp_val;
    logic              irq_en, status_rd;
    logic [NCH-1:0]    pwm_hi, pwm_lo;
    logic [NCH*CW-1:0] ch_cnt;
    logic [NF-1:0]     flt_stat;
    logic              irq, cmp_match;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // model state
    bit [NF-1:0]  m_stat;
    bit [NCH-1:0] m_hold, m_protq;
    int           m_cnt [NCH];
    bit           m_irq;

    pwm_fault_guard #(.NF(NF), .NCH(NCH), .CW(CW)) i_pwm_fault_guard (
        .clk(clk), .rst(rst), .fault_in(fault_in), .flt_pol(flt_pol),
        .flt_mode(flt_mode), .flt_clr(flt_clr), .flt_mask(flt_mask),
        .ch_en(ch_en), .safe_hi(safe_hi), .safe_lo(safe_lo), .duty(duty),
        .period(period), .cmp_val(cmp_val), .irq_en(irq_en),
        .status_rd(status_rd), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .ch_cnt(ch_cnt), .flt_stat(flt_stat), .irq(irq), .cmp_match(cmp_match)
    );

    always begin
        #(CLK_PERIOD/2);
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_eff(input int f);
        bit act;
        act = (fault_in[f] == flt_pol[f]);
        return act | (flt_mode[f] & m_stat[f]);
    endfunction

    function automatic bit f_prot(input int c);
        bit p = 0;
        for (int f = 0; f < NF; f++)
            if (flt_mask[c*NF+f] && f_eff(f)) p = 1;
        return ch_en[c] & p;
    endfunction

    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            bit fr;
            bit on;
            int dty;
            fr  = f_prot(c) | m_hold[c];
            dty = int'(duty[c*CW +: CW]);
            on  = (m_cnt[c] < dty);
            if (fr) begin
                chk(m_hold[c] && !f_prot(c) ? "R8 hi" : "R2 hi", int'(pwm_hi[c]), int'(safe_hi[c]));
                chk(m_hold[c] && !f_prot(c) ? "R8 lo" : "R2 lo", int'(pwm_lo[c]), int'(safe_lo[c]));
            end else if (ch_en[c]) begin
                chk("R5 hi", int'(pwm_hi[c]), int'(on));
                chk("R5 lo", int'(pwm_lo[c]), int'(!on));
            end else begin
                chk("R5 off hi", int'(pwm_hi[c]), 0);
                chk("R5 off lo", int'(pwm_lo[c]), 0);
            end
            chk("R4 count", int'(ch_cnt[c*CW +: CW]), m_cnt[c]);
        end
        for (int f = 0; f < NF; f++)
            chk(flt_mode[f] ? "R7 stat" : "R6 stat", int'(flt_stat[f]), int'(m_stat[f]));
        chk("R9/R10 irq", int'(irq), int'(m_irq));
        chk("R11 cmp", int'(cmp_match),
            int'(ch_en[0] && !(f_prot(0) | m_hold[0]) && m_cnt[0] == int'(cmp_val)));
    endtask

    task automatic advance_model();
        bit [NCH-1:0] p;
        bit entry = 0;
        for (int c = 0; c < NCH; c++) begin
            p[c] = f_prot(c);
            if (p[c] && !m_protq[c]) entry = 1;
        end
        for (int c = 0; c < NCH; c++) begin
            if (!ch_en[c] || p[c] || m_hold[c]) m_cnt[c] = 0;
            else if (m_cnt[c] + 1 >= int'(period)) m_cnt[c] = 0;
            else m_cnt[c] = m_cnt[c] + 1;
        end
        for (int f = 0; f < NF; f++) begin
            bit act;
            act = (fault_in[f] == flt_pol[f]);
            m_stat[f] = act | (flt_mode[f] & m_stat[f] & ~flt_clr[f]);
        end
        if (irq_en && entry) m_irq = 1;
        else if (status_rd) m_irq = 0;
        m_hold  = p;
        m_protq = p;
    endtask

    task automatic step();
        #1;
        check_all();
        advance_model();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        fault_in = ~flt_pol;
        flt_clr = '0;
        status_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        rst = 1;
        fault_in = '0; flt_pol = '1; flt_mode = '0; flt_clr = '0;
        flt_mask = '0; ch_en = '0; safe_hi = '0; safe_lo = '0;
        duty = '0; period = 8'd6; cmp_val = '0; irq_en = 0; status_rd = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_stat = '0; m_hold = '0; m_protq = '0; m_irq = 0;
        for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        // reset state
        #1;
        chk("R4 reset count", int'(ch_cnt), 0);
        chk("R6 reset stat", int'(flt_stat), 0);
        chk("R9 reset irq", int'(irq), 0);
        step();

        // directed: forcing with clock stopped, active-low fault 0 on channel 1
        flt_pol = 4'b1110; flt_mode = '0; flt_mask = 16'h0010;
        ch_en = '1; safe_hi = 4'b0010; safe_lo = 4'b0000;
        duty = {8'd3, 8'd3, 8'd3, 8'd3}; period = 8'd5;
        idle_inputs();
        repeat (4) step();
        clk_run = 0;
        #(CLK_PERIOD * 2);
        fault_in[0] = 1'b0;
        #2;
        chk("R1 R3 forced hi stopped clock", int'(pwm_hi[1]), 1);
        chk("R3 forced lo stopped clock", int'(pwm_lo[1]), 0);
        chk("R2 unmasked ch2 normal", int'(pwm_lo[2] | pwm_hi[2]), 1);
        fault_in[0] = 1'b1;
        #2;
        chk("R3 release stopped clock", int'(pwm_hi[1] ^ pwm_lo[1]), 1);
        clk_run = 1;
        advance_model();
        @(negedge clk);

        // directed: forcing, hold cycle, restart at count 0
        fault_in[0] = 1'b0;
        step();
        chk("R4 held", int'(ch_cnt[1*CW +: CW]), 0);
        step();
        fault_in[0] = 1'b1;
        step();                       // release cycle still forced (hold)
        #1;
        chk("R8 restart count", int'(ch_cnt[1*CW +: CW]), 0);
        chk("R8 normal drive", int'(pwm_hi[1]), 1);
        @(negedge clk); advance_model();
        // keep model aligned: the extra cycle above
        repeat (3) step();

        // directed: latched fault 2 on channel 0
        flt_pol = 4'b1111; flt_mode = 4'b0100; flt_mask = 16'h0004;
        idle_inputs(); irq_en = 1;
        step(); step();
        status_rd = 1; step(); status_rd = 0;
        fault_in[2] = 1; step();
        fault_in[2] = 0;
        repeat (3) step();
        #1;
        chk("R7 latched stat", int'(flt_stat[2]), 1);
        chk("R7 latched keeps forcing", int'(pwm_hi[0]), int'(safe_hi[0]));
        @(negedge clk); advance_model();
        fault_in[2] = 1; flt_clr[2] = 1; step();
        #1; chk("R7 clear refused while active", int'(flt_stat[2]), 1);
        @(negedge clk); advance_model();
        fault_in[2] = 0; step();
        flt_clr[2] = 0;
        step();
        #1; chk("R7 cleared", int'(flt_stat[2]), 0);
        @(negedge clk); advance_model();
        repeat (3) step();

        // directed: read and new entry in the same cycle
        flt_mode = '0; flt_mask = 16'h0001; idle_inputs();
        status_rd = 1; step(); status_rd = 0;
        repeat (3) step();
        fault_in[0] = 1; step();
        fault_in[0] = 0; repeat (3) step();
        #1; chk("R9 pending", int'(irq), 1);
        @(negedge clk); advance_model();
        fault_in[0] = 1; status_rd = 1; step();
        status_rd = 0;
        #1; chk("R10 set wins over read", int'(irq), 1);
        @(negedge clk); advance_model();
        status_rd = 1; step(); status_rd = 0;
        #1; chk("R10 cleared with fault held", int'(irq), 0);
        @(negedge clk); advance_model();
        fault_in[0] = 0; repeat (3) step();

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            if (i % 64 == 0) begin
                flt_pol  = NF'($urandom);
                flt_mode = NF'($urandom);
                flt_mask = (NCH*NF)'($urandom);
                safe_hi  = NCH'($urandom);
                safe_lo  = NCH'($urandom);
                duty     = (NCH*CW)'($urandom);
                for (int c = 0; c < NCH; c++) duty[c*CW +: CW] = CW'($urandom_range(0, 9));
                period   = CW'($urandom_range(0, 9));
                cmp_val  = CW'($urandom_range(0, 8));
            end
            for (int f = 0; f < NF; f++)
                fault_in[f] = ($urandom_range(0, 7) == 0) ? flt_pol[f] : ~flt_pol[f];
            if ($urandom_range(0, 15) == 0) ch_en = NCH'($urandom);
            flt_clr   = ($urandom_range(0, 3) == 0) ? NF'($urandom) : '0;
            status_rd = ($urandom_range(0, 3) == 0);
            irq_en    = ($urandom_range(0, 7) != 0);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule